// File: doc/BRIEF.md
# ADC Sample Band Comparator

This block sits after an ADC conversion stage and sorts each valid conversion result into one of three bands using two programmable limits: below the lower limit is the low band, at or above the upper limit is the high band, and anything between is the mid band. The comparison runs in hardware for every result, so no software ever has to read the samples.

Two independent event engines watch the band stream. The trigger engine drives a level output meant to be wired straight to a PWM fault input, so an out-of-band reading can stop the power stage without software. The interrupt engine drives a one-cycle pulse for the processor. Each engine has its own enable, its own mode and its own selected band. There are four modes: always, once with re-arm, hysteresis toward the high band, and hysteresis toward the low band.

Top module: `adc_region_detector`

## Requirements
- R1: On a cycle with `smp_vld` high, the sample is classed high (code 2) when `smp_data >= thr_hi`, else low (code 0) when `smp_data < thr_lo`, else mid (code 1). The high test takes precedence. The class appears on `band_o` one clock after the sample.
- R2: While `rst` is high and on the first cycle after it, `band_o` reads mid (1), and `trig_o` and `irq_o` read 0.
- R3: Mode code 0 (always): after each valid sample, the engine level is 1 if the sample's band equals the engine's band select (same codes as R1) and 0 otherwise.
- R4: Mode code 1 (once): the level goes to 1 only for the first valid sample in the selected band. Later samples in that band give 0. A valid sample outside the band re-arms the engine. Reset and disable also re-arm it.
- R5: Mode code 2 (hysteresis high): the level goes to 1 on a valid high-band sample and stays 1 until a valid low-band sample. Mid-band samples leave it unchanged. The band select is not used.
- R6: Mode code 3 (hysteresis low): the level goes to 1 on a valid low-band sample and stays 1 until a valid high-band sample. Mid-band samples leave it unchanged.
- R7: `irq_o` is a one-cycle pulse, one clock after the sample, when the interrupt engine fires:
  - in modes 0 and 1, on a sample whose level is 1;
  - in modes 2 and 3, when the engine goes from inactive to active.
- R8: While an engine's enable is 0, its output is 0 and its state returns to the reset state.
- R9: On cycles without `smp_vld`, `band_o` and `trig_o` hold their values and `irq_o` is 0.
- R10: A sample equal to `thr_lo` is mid band. A sample equal to `thr_hi` is high band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Conversion result valid strobe |
| smp_data | input | DATA_W | Conversion result |
| thr_lo | input | DATA_W | Lower band limit |
| thr_hi | input | DATA_W | Upper band limit |
| trig_en | input | 1 | Trigger engine enable |
| trig_mode | input | 2 | Trigger engine mode (0 always, 1 once, 2 hyst high, 3 hyst low) |
| trig_band | input | 2 | Band selected for trigger modes 0 and 1 |
| int_en | input | 1 | Interrupt engine enable |
| int_mode | input | 2 | Interrupt engine mode, same codes |
| int_band | input | 2 | Band selected for interrupt modes 0 and 1 |
| trig_o | output | 1 | Registered fault trigger level |
| irq_o | output | 1 | Registered one-cycle interrupt pulse |
| band_o | output | 2 | Band of the last valid sample |

## Verification
The bench builds the block with the default 12-bit sample width. This puts both ends of the range, 0 and 4095, within reach, together with samples exactly on each limit. It runs every trigger mode against a different interrupt mode so that the two engines are seen to keep separate state. It also toggles each enable partway through a stream to show the once re-arm and the hysteresis clear on disable.

// File: rtl/adc_region_pkg.sv
package adc_region_pkg;
  typedef enum logic [1:0] {
    BAND_LO  = 2'd0,
    BAND_MID = 2'd1,
    BAND_HI  = 2'd2
  } band_e;

  typedef enum logic [1:0] {
    MODE_ALWAYS  = 2'd0,
    MODE_ONCE    = 2'd1,
    MODE_HYST_HI = 2'd2,
    MODE_HYST_LO = 2'd3
  } mode_e;
endpackage

// File: rtl/adc_band_classify.sv
module adc_band_classify
  import adc_region_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lim_lo,
  input  logic [DATA_W-1:0] lim_hi,
  output band_e             band
);
  always_comb begin
    if (value >= lim_hi)     band = BAND_HI;
    else if (value < lim_lo) band = BAND_LO;
    else                     band = BAND_MID;
  end
endmodule

// File: rtl/adc_band_engine.sv
module adc_band_engine
  import adc_region_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  vld,
  input  band_e band,
  input  mode_e mode,
  input  band_e sel,
  output logic  level,
  output logic  evt
);
  logic armed_q, active_q;
  logic armed_d, active_d, level_d, evt_d;

  always_comb begin
    armed_d  = armed_q;
    active_d = active_q;
    level_d  = level;
    evt_d    = 1'b0;
    if (!en) begin
      armed_d  = 1'b1;
      active_d = 1'b0;
      level_d  = 1'b0;
    end else if (vld) begin
      unique case (mode)
        MODE_ALWAYS: begin
          level_d = (band == sel);
          evt_d   = (band == sel);
        end
        MODE_ONCE: begin
          if (band == sel) begin
            level_d = armed_q;
            evt_d   = armed_q;
            armed_d = 1'b0;
          end else begin
            level_d = 1'b0;
            armed_d = 1'b1;
          end
        end
        MODE_HYST_HI: begin
          if (band == BAND_HI) begin
            evt_d    = !active_q;
            active_d = 1'b1;
          end else if (band == BAND_LO) begin
            active_d = 1'b0;
          end
          level_d = active_d;
        end
        MODE_HYST_LO: begin
          if (band == BAND_LO) begin
            evt_d    = !active_q;
            active_d = 1'b1;
          end else if (band == BAND_HI) begin
            active_d = 1'b0;
          end
          level_d = active_d;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b1;
      active_q <= 1'b0;
      level    <= 1'b0;
      evt      <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      active_q <= active_d;
      level    <= level_d;
      evt      <= evt_d;
    end
  end
endmodule

// File: rtl/adc_region_detector.sv
module adc_region_detector
  import adc_region_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic              trig_en,
  input  logic [1:0]        trig_mode,
  input  logic [1:0]        trig_band,
  input  logic              int_en,
  input  logic [1:0]        int_mode,
  input  logic [1:0]        int_band,
  output logic              trig_o,
  output logic              irq_o,
  output logic [1:0]        band_o
);
  localparam int N_ENG = 2;

  band_e cur_band;
  band_e band_q;

  adc_band_classify #(.DATA_W(DATA_W)) u_cls (
    .value (smp_data),
    .lim_lo(thr_lo),
    .lim_hi(thr_hi),
    .band  (cur_band)
  );

  always_ff @(posedge clk) begin
    if (rst)          band_q <= BAND_MID;
    else if (smp_vld) band_q <= cur_band;
  end
  assign band_o = band_q;

  logic [N_ENG-1:0] eng_en, eng_lvl, eng_evt;
  logic [1:0]       eng_mode [N_ENG];
  logic [1:0]       eng_sel  [N_ENG];

  assign eng_en      = {int_en, trig_en};
  assign eng_mode[0] = trig_mode;
  assign eng_mode[1] = int_mode;
  assign eng_sel[0]  = trig_band;
  assign eng_sel[1]  = int_band;

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    adc_band_engine u_eng (
      .clk  (clk),
      .rst  (rst),
      .en   (eng_en[g]),
      .vld  (smp_vld),
      .band (cur_band),
      .mode (mode_e'(eng_mode[g])),
      .sel  (band_e'(eng_sel[g])),
      .level(eng_lvl[g]),
      .evt  (eng_evt[g])
    );
  end

  assign trig_o = eng_lvl[0];
  assign irq_o  = eng_evt[1];
endmodule

// File: rtl/adc_region_detector_chk.sv
module adc_region_detector_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_vld,
  input logic [DATA_W-1:0] smp_data,
  input logic [DATA_W-1:0] thr_lo,
  input logic [DATA_W-1:0] thr_hi,
  input logic              trig_en,
  input logic [1:0]        trig_mode,
  input logic [1:0]        trig_band,
  input logic              int_en,
  input logic [1:0]        int_mode,
  input logic [1:0]        int_band,
  input logic              trig_o,
  input logic              irq_o,
  input logic [1:0]        band_o
);
  // R2
  reset_state_chk: assert property (@(posedge clk) rst |=> (band_o == 2'd1) && !trig_o && !irq_o);
  // R1
  band_code_chk: assert property (@(posedge clk) disable iff (rst) band_o != 2'd3);
  // R10
  high_edge_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && (smp_data == thr_hi) |=> band_o == 2'd2);
  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(band_o) && $stable(trig_o) && !irq_o);
  // R8
  trig_off_chk: assert property (@(posedge clk) disable iff (rst) !trig_en |=> !trig_o);
  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (rst) !int_en |=> !irq_o);
  // R3
  always_mode_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && trig_en && trig_mode == 2'd0 |=> trig_o == (band_o == $past(trig_band)));
  // R5
  hyst_hi_set_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && trig_en && trig_mode == 2'd2 && smp_data >= thr_hi |=> trig_o);
endmodule

bind adc_region_detector adc_region_detector_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/adc_region_detector_test.sv
module adc_region_detector_test;
  localparam int DW    = 12;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [DW-1:0] thr_lo = 12'd1000;
  logic [DW-1:0] thr_hi = 12'd3000;
  logic trig_en = 1'b1, int_en = 1'b1;
  logic [1:0] trig_mode = 2'd0, trig_band = 2'd2, int_mode = 2'd0, int_band = 2'd2;
  logic trig_o, irq_o;
  logic [1:0] band_o;

  int errors = 0;
  int checks = 0;

  // model state, index 0 = trigger engine, 1 = interrupt engine
  int m_band;
  int m_armed [2];
  int m_active[2];
  int m_level [2];
  int m_evt   [2];

  always #(CLK_P/2) clk = ~clk;

  adc_region_detector #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi),
    .trig_en(trig_en), .trig_mode(trig_mode), .trig_band(trig_band),
    .int_en(int_en), .int_mode(int_mode), .int_band(int_band),
    .trig_o(trig_o), .irq_o(irq_o), .band_o(band_o)
  );

  function automatic int classify(int d, int lo, int hi);
    if (d >= hi) return 2;
    if (d < lo) return 0;
    return 1;
  endfunction

  task automatic model_reset();
    m_band = 1;
    for (int k = 0; k < 2; k++) begin
      m_armed[k] = 1; m_active[k] = 0; m_level[k] = 0; m_evt[k] = 0;
    end
  endtask

  task automatic model_eng(int k, bit en, int mode, int sel, bit v, int b);
    m_evt[k] = 0;
    if (!en) begin
      m_armed[k] = 1; m_active[k] = 0; m_level[k] = 0;
    end else if (v) begin
      if (mode == 0) begin
        m_level[k] = (b == sel); m_evt[k] = (b == sel);
      end else if (mode == 1) begin
        if (b == sel) begin
          m_level[k] = m_armed[k]; m_evt[k] = m_armed[k]; m_armed[k] = 0;
        end else begin
          m_level[k] = 0; m_armed[k] = 1;
        end
      end else begin
        int on_b  = (mode == 2) ? 2 : 0;
        int off_b = (mode == 2) ? 0 : 2;
        if (b == on_b) begin
          m_evt[k] = (m_active[k] == 0); m_active[k] = 1;
        end else if (b == off_b) begin
          m_active[k] = 0;
        end
        m_level[k] = m_active[k];
      end
    end
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(bit v, int d);
    string btag, ttag;
    btag = !v ? "R9" : ((d == thr_lo || d == thr_hi) ? "R10" : "R1");
    if (!trig_en) ttag = "R8";
    else if (!v) ttag = "R9";
    else case (trig_mode)
      2'd0: ttag = "R3";
      2'd1: ttag = "R4";
      2'd2: ttag = "R5";
      default: ttag = "R6";
    endcase
    check({btag, " band"}, band_o, m_band);
    check({ttag, " trig"}, trig_o, m_level[0]);
    check(int_en ? "R7 irq" : "R8 irq", irq_o, m_evt[1]);
  endtask

  task automatic step(bit v, int d);
    smp_vld  = v;
    smp_data = DW'(d);
    @(posedge clk);
    if (v) m_band = classify(d, thr_lo, thr_hi);
    model_eng(0, trig_en, trig_mode, trig_band, v, classify(d, thr_lo, thr_hi));
    model_eng(1, int_en, int_mode, int_band, v, classify(d, thr_lo, thr_hi));
    @(negedge clk);
    compare(v, d);
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_vld = 1'b0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk);
    // R2: reset values
    check("R2 band", band_o, 1);
    check("R2 trig", trig_o, 0);
    check("R2 irq", irq_o, 0);
    rst = 1'b0;
  endtask

  int seq[14] = '{500, 2000, 3000, 3500, 4095, 2000, 3100, 999, 1000, 0, 2999, 4095, 1500, 0};

  initial begin
    do_reset();
    for (int m = 0; m < 4; m++) begin
      trig_mode = 2'(m);
      int_mode  = 2'(3 - m);
      trig_band = 2'(m % 3);
      int_band  = 2'((m + 1) % 3);
      for (int i = 0; i < 14; i++) begin
        step(1'b1, seq[i]);
        if (i % 3 == 2) step(1'b0, 0);
        if (i % 4 == 1) step(1'b1, seq[i]);
      end
      // R8: disable mid-stream, then resume
      trig_en = 1'b0; step(1'b1, 4095); step(1'b1, 500);
      int_en  = 1'b0; step(1'b1, 4095); step(1'b1, 0);
      trig_en = 1'b1; int_en = 1'b1;
      step(1'b1, 4095); step(1'b1, 4095); step(1'b1, 0); step(1'b1, 0);
    end
    // R10: samples on each limit
    thr_lo = 12'd0; thr_hi = 12'd4095;
    trig_mode = 2'd0; trig_band = 2'd1;
    step(1'b1, 0); step(1'b1, 4095); step(1'b1, 4094);
    thr_lo = 12'd1000; thr_hi = 12'd3000;
    step(1'b1, 1000); step(1'b1, 3000); step(1'b1, 2999);
    do_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule